// File: doc/BRIEF.md
# Fused-operation integer ALU

This execution unit computes, in a single pass, the combined result of the two-instruction sequences that an instruction-fusion stage merges into one internal operation. It covers shift-then-add, zero-extend-word-then-shift, byte extraction, masked OR, odd-add, word-add-then-extend, logic-then-extract and the build of a 32-bit constant from an upper and a lower immediate part.

Each issued operation presents two 64-bit operands, a 32-bit immediate, a valid bit and a 5-bit operation code. The result, its valid flag and an illegal-code flag appear one clock later from registers. Unassigned codes produce a zero result with the illegal flag raised.

Top module: `fused_alu`

## Requirements
- R1: Outputs are registered with one cycle of latency: `res_valid` in a cycle equals `in_valid` of the previous cycle. A synchronous active-high `rst` clears `res_valid`, `res_illegal` and `res_data`.
- R2: Codes 0, 1, 2 return the low 32 bits of `in_a` zero-extended to 64 bits and then shifted left by 1, 2 and 3 respectively.
- R3: Code 3 returns `(in_a >> 8) & 0xFF` (logical shift).
- R4: Code 4 returns `(in_a << 4) + in_b` modulo 2^64; codes 5, 6, 7, 8 return `(in_a >> N) + in_b` with a logical shift by N = 29, 30, 31, 32.
- R5: Code 9 returns `(in_a & 1) + in_b` in 64 bits; code 10 adds `in_a & 1` to the low 32 bits of `in_b` in 32 bits and sign-extends the 32-bit sum.
- R6: With S the 32-bit sum of the low words of `in_a` and `in_b`, codes 11, 12, 13, 14 return S[7:0] zero-extended, S[0] alone, S[15:0] zero-extended and S[15:0] sign-extended.
- R7: Code 15 returns `in_a` with bits 7:0 cleared, ORed with `in_b`.
- R8: Codes 16 to 23 apply a logic function chosen by code bits 1:0 (0 AND, 1 OR, 2 XOR of the operands, 3 byte-wise OR-combine of `in_a`, where each byte becomes 0xFF if nonzero, else 0x00); codes 16 to 19 return bit 0 of it only, codes 20 to 23 return its low 16 bits zero-extended.
- R9: With U = `in_imm[31:12]` and L = `in_imm[11:0]`, code 24 returns sign-extended (U << 12) plus sign-extended L as a 64-bit sum; code 25 forms the same sum in 32 bits and sign-extends it.
- R10: Codes 26 to 31 return zero with `res_illegal` high; for codes 0 to 25 `res_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 64 | Operand 1 |
| in_b | input | 64 | Operand 2 |
| in_imm | input | 32 | Upper (31:12) and lower (11:0) immediate parts |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_data | output | 64 | Result |
| res_illegal | output | 1 | Unassigned operation code was issued |

## Verification
Every one of the 32 codes is swept against a grid of operand and immediate pairs, among them operand 1 at all ones, a low word of 0x7FFFFFFF against operand 2 of one so the word sum carries into bit 31, and values that tell a logical right shift by 32 from an arithmetic one. Immediates with the lower part's sign bit set and the upper part at 0x80000 separate the full-width constant from the word form, since only the latter wraps at 32 bits. Idle cycles and reset confirm the valid flag tracks issue with exactly one cycle of delay.

// File: rtl/fused_alu_pkg.sv
`timescale 1ns/1ps
package fused_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ZW_SL1    = 5'd0,
    OP_ZW_SL2    = 5'd1,
    OP_ZW_SL3    = 5'd2,
    OP_BYTE1     = 5'd3,
    OP_SL4_ADD   = 5'd4,
    OP_SR29_ADD  = 5'd5,
    OP_SR30_ADD  = 5'd6,
    OP_SR31_ADD  = 5'd7,
    OP_SR32_ADD  = 5'd8,
    OP_ODD_ADD   = 5'd9,
    OP_ODD_ADDW  = 5'd10,
    OP_WADD_B8   = 5'd11,
    OP_WADD_B1   = 5'd12,
    OP_WADD_Z16  = 5'd13,
    OP_WADD_S16  = 5'd14,
    OP_MASK_OR   = 5'd15,
    OP_AND_LSB   = 5'd16,
    OP_OR_LSB    = 5'd17,
    OP_XOR_LSB   = 5'd18,
    OP_OCB_LSB   = 5'd19,
    OP_AND_Z16   = 5'd20,
    OP_OR_Z16    = 5'd21,
    OP_XOR_Z16   = 5'd22,
    OP_OCB_Z16   = 5'd23,
    OP_IMM32     = 5'd24,
    OP_IMM32W    = 5'd25
  } fop_e;
endpackage

// File: rtl/fa_shift_add.sv
`timescale 1ns/1ps
module fa_shift_add
  import fused_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              hit
);
  localparam int WORD_W  = DATA_W / 2;
  localparam int SR_BASE = WORD_W - 3;
  localparam int N_SR    = 4;

  logic [DATA_W-1:0] a_zw;
  logic [DATA_W-1:0] sr_sum [N_SR];

  assign a_zw = {{WORD_W{1'b0}}, a[WORD_W-1:0]};

  // right-shift-then-add variants, shift amounts SR_BASE .. SR_BASE+3
  for (genvar g = 0; g < N_SR; g++) begin : g_sr
    assign sr_sum[g] = (a >> (SR_BASE + g)) + b;
  end

  always_comb begin
    hit = 1'b1;
    y   = '0;
    case (op)
      OP_ZW_SL1:   y = a_zw << 1;
      OP_ZW_SL2:   y = a_zw << 2;
      OP_ZW_SL3:   y = a_zw << 3;
      OP_BYTE1:    y = {{(DATA_W-8){1'b0}}, a[15:8]};
      OP_SL4_ADD:  y = (a << 4) + b;
      OP_SR29_ADD: y = sr_sum[0];
      OP_SR30_ADD: y = sr_sum[1];
      OP_SR31_ADD: y = sr_sum[2];
      OP_SR32_ADD: y = sr_sum[3];
      OP_ODD_ADD:  y = {{(DATA_W-1){1'b0}}, a[0]} + b;
      OP_MASK_OR:  y = {a[DATA_W-1:8], 8'h00} | b;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fa_word_ext.sv
`timescale 1ns/1ps
module fa_word_ext
  import fused_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]        op,
  input  logic [DATA_W/2-1:0]    a_w,
  input  logic [DATA_W/2-1:0]    b_w,
  output logic [DATA_W-1:0]      y,
  output logic                   hit
);
  localparam int WORD_W = DATA_W / 2;

  logic [WORD_W-1:0] wsum;
  logic [WORD_W-1:0] odd_sum;

  assign wsum    = a_w + b_w;
  assign odd_sum = {{(WORD_W-1){1'b0}}, a_w[0]} + b_w;

  always_comb begin
    hit = 1'b1;
    y   = '0;
    case (op)
      OP_ODD_ADDW: y = {{WORD_W{odd_sum[WORD_W-1]}}, odd_sum};
      OP_WADD_B8:  y = {{(DATA_W-8){1'b0}}, wsum[7:0]};
      OP_WADD_B1:  y = {{(DATA_W-1){1'b0}}, wsum[0]};
      OP_WADD_Z16: y = {{(DATA_W-16){1'b0}}, wsum[15:0]};
      OP_WADD_S16: y = {{(DATA_W-16){wsum[15]}}, wsum[15:0]};
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fa_logic_ext.sv
`timescale 1ns/1ps
module fa_logic_ext
  import fused_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              hit
);
  localparam int N_BYTES = DATA_W / 8;

  logic [DATA_W-1:0] ocb;
  logic [DATA_W-1:0] lres;

  // byte-wise OR-combine of operand 1
  for (genvar g = 0; g < N_BYTES; g++) begin : g_ocb
    assign ocb[8*g +: 8] = {8{|a[8*g +: 8]}};
  end

  // code bits 1:0 pick the function, bit 2 picks halfword vs single bit
  always_comb begin
    case (op[1:0])
      2'd0:    lres = a & b;
      2'd1:    lres = a | b;
      2'd2:    lres = a ^ b;
      default: lres = ocb;
    endcase
  end

  assign hit = (op[OP_W-1:OP_W-2] == 2'b10);
  assign y   = !hit    ? '0 :
               op[2]   ? {{(DATA_W-16){1'b0}}, lres[15:0]} :
                         {{(DATA_W-1){1'b0}}, lres[0]};
endmodule

// File: rtl/fa_imm32.sv
`timescale 1ns/1ps
module fa_imm32
  import fused_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]  op,
  input  logic [31:0]      imm,
  output logic [DATA_W-1:0] y,
  output logic             hit
);
  localparam int HI_W = 20;
  localparam int LO_W = 12;

  logic [31:0]       up_w;
  logic [31:0]       lo_w;
  logic [31:0]       sum_w;
  logic [DATA_W-1:0] sum_x;

  assign up_w  = {imm[31:LO_W], {LO_W{1'b0}}};
  assign lo_w  = {{(32-LO_W){imm[LO_W-1]}}, imm[LO_W-1:0]};
  assign sum_w = up_w + lo_w;
  assign sum_x = {{(DATA_W-32){up_w[31]}}, up_w} + {{(DATA_W-32){lo_w[31]}}, lo_w};

  always_comb begin
    hit = 1'b1;
    y   = '0;
    case (op)
      OP_IMM32:  y = sum_x;
      OP_IMM32W: y = {{(DATA_W-32){sum_w[31]}}, sum_w};
      default:   hit = 1'b0;
    endcase
  end

  localparam int UNUSED_HI = HI_W;
endmodule

// File: rtl/fused_alu.sv
`timescale 1ns/1ps
module fused_alu
  import fused_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [31:0]       in_imm,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_illegal
);
  localparam int WORD_W = DATA_W / 2;
  localparam int N_UNIT = 4;

  logic [DATA_W-1:0] u_y   [N_UNIT];
  logic [N_UNIT-1:0] u_hit;
  logic [DATA_W-1:0] sel_y;
  logic              bad_op;

  fa_shift_add #(.DATA_W(DATA_W)) u_sa (
    .op(in_op), .a(in_a), .b(in_b), .y(u_y[0]), .hit(u_hit[0]));

  fa_word_ext #(.DATA_W(DATA_W)) u_we (
    .op(in_op), .a_w(in_a[WORD_W-1:0]), .b_w(in_b[WORD_W-1:0]),
    .y(u_y[1]), .hit(u_hit[1]));

  fa_logic_ext #(.DATA_W(DATA_W)) u_le (
    .op(in_op), .a(in_a), .b(in_b), .y(u_y[2]), .hit(u_hit[2]));

  fa_imm32 #(.DATA_W(DATA_W)) u_im (
    .op(in_op), .imm(in_imm), .y(u_y[3]), .hit(u_hit[3]));

  // one-hot select across the units
  always_comb begin
    sel_y = '0;
    for (int i = 0; i < N_UNIT; i++) begin
      if (u_hit[i]) sel_y = sel_y | u_y[i];
    end
  end

  assign bad_op = (u_hit == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_data    <= '0;
    end else begin
      res_valid   <= in_valid;
      res_illegal <= in_valid & bad_op;
      res_data    <= bad_op ? '0 : sel_y;
    end
  end

  // R10: at most one unit claims any code
  p_one_unit_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(u_hit));

  // R1: issue shows up as valid one cycle later
  p_valid_next_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  // R1: no issue, no valid
  p_idle_next_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  // R10: an illegal code yields a zero valid result
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> (res_valid && res_data == '0));

  // R8: single-bit logic extracts leave upper bits clear
  p_lsb_only_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= OP_AND_LSB && in_op <= OP_OCB_LSB)
      |=> (res_data[DATA_W-1:1] == '0));

  // R6: halfword zero-extend of the word sum clears the upper bits
  p_zext_hw_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_WADD_Z16) |=> (res_data[DATA_W-1:16] == '0));
endmodule

// File: tb/tb_fused_alu.sv
`timescale 1ns/1ps
module tb_fused_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  in_op;
  logic [63:0] in_a, in_b;
  logic [31:0] in_imm;
  logic        res_valid;
  logic [63:0] res_data;
  logic        res_illegal;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  fused_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .res_valid(res_valid), .res_data(res_data), .res_illegal(res_illegal));

  function automatic string req_of(int op);
    if (op <= 2)  return "R2";
    if (op == 3)  return "R3";
    if (op <= 8)  return "R4";
    if (op <= 10) return "R5";
    if (op <= 14) return "R6";
    if (op == 15) return "R7";
    if (op <= 23) return "R8";
    if (op <= 25) return "R9";
    return "R10";
  endfunction

  function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b,
                                        logic [31:0] imm);
    logic [31:0] s, w, up, lo;
    logic [63:0] f, ocb;
    s = a[31:0] + b[31:0];
    for (int k = 0; k < 8; k++) ocb[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
    case (op & 3)
      0: f = a & b;
      1: f = a | b;
      2: f = a ^ b;
      default: f = ocb;
    endcase
    up = {imm[31:12], 12'h000};
    lo = {{20{imm[11]}}, imm[11:0]};
    if (op <= 2)  return {32'h0, a[31:0]} << (op + 1);
    if (op == 3)  return (a >> 8) & 64'hFF;
    if (op == 4)  return (a << 4) + b;
    if (op <= 8)  return (a >> (op + 24)) + b;
    if (op == 9)  return {63'h0, a[0]} + b;
    if (op == 10) begin w = b[31:0] + {31'h0, a[0]}; return {{32{w[31]}}, w}; end
    if (op == 11) return {56'h0, s[7:0]};
    if (op == 12) return {63'h0, s[0]};
    if (op == 13) return {48'h0, s[15:0]};
    if (op == 14) return {{48{s[15]}}, s[15:0]};
    if (op == 15) return (a & ~64'hFF) | b;
    if (op <= 19) return {63'h0, f[0]};
    if (op <= 23) return {48'h0, f[15:0]};
    if (op == 24) return {{32{up[31]}}, up} + {{32{lo[31]}}, lo};
    if (op == 25) begin w = up + lo; return {{32{w[31]}}, w}; end
    return 64'h0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(int op, logic [63:0] a, logic [63:0] b, logic [31:0] imm);
    @(negedge clk);
    in_valid = 1'b1; in_op = op[4:0]; in_a = a; in_b = b; in_imm = imm;
    @(negedge clk);
    check("R1", {63'h0, res_valid}, 64'h1, "valid after issue");
    check(req_of(op), res_data, model(op, a, b, imm), $sformatf("data op=%0d", op));
    check("R10", {63'h0, res_illegal}, {63'h0, op >= 26}, $sformatf("illegal op=%0d", op));
  endtask

  logic [63:0] av [8];
  logic [63:0] bv [8];
  logic [31:0] iv [8];

  initial begin
    av[0] = 64'hFFFF_FFFF_FFFF_FFFF; bv[0] = 64'h0000_0000_0000_0001;
    av[1] = 64'h0000_0000_7FFF_FFFF; bv[1] = 64'h0000_0000_0000_0001;
    av[2] = 64'h8000_0000_0000_0001; bv[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    av[3] = 64'h1234_5678_9ABC_DEF0; bv[3] = 64'h0F0F_0000_00FF_8001;
    av[4] = 64'h0000_0000_0000_0000; bv[4] = 64'h0000_0000_0000_0000;
    av[5] = 64'h0000_0001_0000_0000; bv[5] = 64'h0000_0000_7FFF_FFFF;
    av[6] = 64'hFFFF_FFFF_0000_7F00; bv[6] = 64'h0000_0000_0000_80FF;
    av[7] = 64'h00FF_0000_1000_00FE; bv[7] = 64'h8000_0000_8000_0000;
    iv[0] = 32'h8000_0800; iv[1] = 32'h7FFF_F7FF; iv[2] = 32'hFFFF_A001;
    iv[3] = 32'h0000_0FFF; iv[4] = 32'h0000_0000; iv[5] = 32'h8000_0000;
    iv[6] = 32'h7FFF_F800; iv[7] = 32'h1234_5ABC;
    rst = 1'b1; in_valid = 1'b1; in_op = 5'd31; in_a = '1; in_b = '1; in_imm = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {63'h0, res_valid}, 64'h0, "valid in reset");
    check("R1", {63'h0, res_illegal}, 64'h0, "illegal in reset");
    check("R1", res_data, 64'h0, "data in reset");
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R1", {63'h0, res_valid}, 64'h0, "valid when idle");
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          issue(op, av[i], bv[j], iv[(i + j) % 8]);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", {63'h0, res_valid}, 64'h0, "valid drops after idle");
    // R1: reset mid-stream clears valid
    in_valid = 1'b1; in_op = 5'd4; rst = 1'b1;
    @(negedge clk);
    check("R1", {63'h0, res_valid}, 64'h0, "valid under reset");
    rst = 1'b0; in_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule